// File: doc/BRIEF.md
# Square-Wave Test Signal Generator

This block divides a channel clock-enable stream down to a square wave with an even duty cycle. A capture channel uses it to test itself: the input selector of the channel can pick this wave as its source code 4, so the capture path can be exercised without any external stimulus. The selector is a separate block. Codes 5 to 7 of that selector fall back to source 0. The generator shares its clock source with the capture channel it drives.

A scaler value N sets the wave. The output inverts once every N+1 clock-enable ticks, so one full period is 2(N+1) ticks. While the enable input is low, the output is held low and the divider counter is cleared. A new scaler value is picked up only at a toggle, so no half-period is ever cut short. The value also loads while the generator is disabled, so the first half-period after enable uses the value that was present just before enable rose.

Top module: `tsg_test_signal_gen`

## Requirements
- R1: After reset the output `test_out` is low.
- R2: A cycle with `enable` low drives `test_out` low at the next clock edge and clears the tick counter. After re-enabling, the first toggle needs a full N+1 ticks again.
- R3: While enabled, `test_out` inverts exactly on every (N+1)-th tick, giving a period of 2(N+1) ticks with equal high and low halves.
- R4: With N = 0 the output inverts on every tick.
- R5: Cycles with `tick` low never change `test_out` while `enable` stays high.
- R6: A scaler change during a half-period does not alter that half-period. The new value sets the length of the half-periods from the next toggle on.
- R7: The first toggle after `enable` rises happens on the (N+1)-th tick, where N is the scaler value present in the last cycle before `enable` rose. `test_out` is low up to that tick.
- R8: The full scaler range works: N = 2^CNT_W - 1 gives half-periods of 2^CNT_W ticks with no counter wrap error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable tick that advances the divider |
| enable | input | 1 | Generator enable; low holds output low and clears the counter |
| scaler | input | CNT_W | Half-period length minus one, in ticks |
| test_out | output | 1 | Square-wave test signal (selector source code 4) |

## Verification
The bench sweeps scaler values 0 to 7 with ticks on every cycle and with ticks spaced by idle cycles. It checks the output after every tick against floor(k/(N+1)) mod 2. The spaced ticks show whether only ticks advance the divider, and N = 0 shows whether the compare is off by one. Two more sequences change the scaler in the middle of a half-period and drop enable in the middle of a run. These show whether the reload happens only at a toggle and whether disabling really clears the counter. A run at the largest scaler value checks the wide end of the counter.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    // Default divider width; the scaler input and tick counter use it.
    parameter int DEF_CNT_W = 16;
endpackage

// File: rtl/tsg_tick_counter.sv
module tsg_tick_counter #(
    parameter int CNT_W = tsg_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] scaler,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_limit;

    assign at_limit = (st_q.count == st_q.limit);
    assign wrap     = run && tick && at_limit;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            // Held idle: counter cleared, limit tracks the scaler input.
            st_d.count = '0;
            st_d.limit = scaler;
        end else if (tick) begin
            if (at_limit) begin
                // Half-period done: reload the limit only here.
                st_d.count = '0;
                st_d.limit = scaler;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tsg_toggle_stage.sv
module tsg_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    output logic wave
);
    typedef struct packed {
        logic level;
    } tog_state_t;

    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.level = 1'b0;
        end else if (wrap) begin
            st_d.level = ~st_q.level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave = st_q.level;
endmodule

// File: rtl/tsg_test_signal_gen.sv
module tsg_test_signal_gen #(
    parameter int CNT_W = tsg_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] scaler,
    output logic             test_out
);
    logic wrap_w;

    tsg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .tick   (tick),
        .scaler (scaler),
        .wrap   (wrap_w)
    );

    tsg_toggle_stage u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .wrap  (wrap_w),
        .wave  (test_out)
    );
endmodule

// File: rtl/tsg_test_signal_gen_chk.sv
module tsg_test_signal_gen_chk #(
    parameter int CNT_W = tsg_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             enable,
    input logic [CNT_W-1:0] scaler,
    input logic             test_out
);
    // Checker-side tick model built from the requirement text only.
    logic [CNT_W-1:0] ck_cnt, ck_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_cnt <= '0;
            ck_lim <= '0;
        end else if (!enable) begin
            ck_cnt <= '0;
            ck_lim <= scaler;
        end else if (tick) begin
            if (ck_cnt == ck_lim) begin
                ck_cnt <= '0;
                ck_lim <= scaler;
            end else begin
                ck_cnt <= ck_cnt + 1'b1;
            end
        end
    end

    assert_low_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !test_out);

    assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(test_out));

    assert_low_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> !test_out);

    assert_toggle_on_last_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && ck_cnt == ck_lim) |=> (test_out != $past(test_out)));

    assert_no_early_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && ck_cnt != ck_lim) |=> $stable(test_out));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (!test_out);
        end
    end
endmodule

bind tsg_test_signal_gen tsg_test_signal_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (enable),
    .scaler   (scaler),
    .test_out (test_out)
);

// File: tb/tsg_test_signal_gen_tb.sv
module tsg_test_signal_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] scaler = '0;
    logic             test_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsg_test_signal_gen #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
        .scaler(scaler), .test_out(test_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: test_out=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One tick, then gap idle cycles with a stability check each (R5).
    task automatic do_tick(input int gap, input logic exp, input string req);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(test_out, exp, req);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(test_out, exp, "R5 idle cycle");
        end
    endtask

    task automatic restart(input logic [CNT_W-1:0] n);
        enable = 1'b0;
        scaler = n;
        @(negedge clk);
        check(test_out, 1'b0, "R2 disabled low");
        enable = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(test_out, 1'b0, "R1 reset low");
        rst_n = 1'b1;
        @(negedge clk);
        check(test_out, 1'b0, "R1 after reset");

        // R3/R4/R7 sweep: scalers 0..7, dense and spaced ticks.
        for (int gap = 0; gap < 3; gap += 2) begin
            for (int n = 0; n < 8; n++) begin
                restart(n[CNT_W-1:0]);
                for (int k = 1; k <= 4 * (n + 1); k++) begin
                    do_tick(gap, 1'((k / (n + 1)) % 2),
                            (n == 0) ? "R4 every tick" : (k <= n + 1) ? "R7 first toggle" : "R3 period");
                end
            end
        end

        // R6: scaler 3 -> 1 changed mid half-period.
        restart(16'd3);
        do_tick(0, 1'b0, "R6 old half");
        do_tick(0, 1'b0, "R6 old half");
        scaler = 16'd1;
        for (int k = 3; k <= 8; k++) begin
            do_tick(1, (k < 4) ? 1'b0 : 1'(((k - 4) / 2 + 1) % 2), "R6 reload at toggle");
        end

        // R2: disable mid-run clears counter and output.
        restart(16'd4);
        for (int k = 1; k <= 7; k++) do_tick(0, 1'((k / 5) % 2), "R3 period");
        enable = 1'b0;
        @(negedge clk);
        check(test_out, 1'b0, "R2 disable forces low");
        enable = 1'b1;
        for (int k = 1; k <= 5; k++) do_tick(0, (k == 5) ? 1'b1 : 1'b0, "R2 counter cleared");

        // R8: largest scaler, one half-period of 65536 ticks.
        restart(16'hFFFF);
        tick = 1'b1;
        repeat (65535) @(negedge clk);
        check(test_out, 1'b0, "R8 before last tick");
        @(negedge clk);
        check(test_out, 1'b1, "R8 toggle at 65536");
        tick = 1'b0;
        @(negedge clk);
        check(test_out, 1'b1, "R5 hold");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule